// File: doc/BRIEF.md
# ATA Multiword DMA Host Sequencer

This block is the host end of a multiword DMA burst on a 16-bit ATA data bus. Once it has been armed with a direction, a word count and two strobe timings, it waits for the device request. It then asserts the acknowledge and issues read or write strobes. Each strobe carries one data word. On the local side, words leave through a valid/ready output stream when data comes in from the device. Words enter through a valid/ready input stream when data goes out to the device. The block drives an output enable for the bus data pins and leaves the pad to the chip.

A burst can end in two ways. The device ends it by withdrawing its request while a strobe is low. The host ends it by releasing the acknowledge after a recovery period, when the local stream cannot take or supply the next word. In both cases the sequencer goes back to waiting. It starts a fresh burst when the request is present and words remain. When the last word has moved and the acknowledge is back high, a one-cycle completion pulse is raised.

The request input is asynchronous and passes through a synchronizer whose depth is a parameter. All strobe timing is counted in clock cycles from the two timing inputs, which are captured at start.

Top module: `mwdma_host_seq`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, dmack_n, dior_n and diow_n are high, and dd_oe, done, busy and rx_valid are low.
- R2: dmack_n falls only while the synchronized request is high. A strobe is low only while dmack_n is low. dmack_n is low for at least one cycle before a strobe falls, and it stays low for at least one full cycle after the last strobe rises.
- R3: Each strobe stays low for exactly act_cycles cycles, with 0 treated as 1. Two consecutive strobes of one burst are separated by exactly rec_cycles+1 high cycles.
- R4: Data-in (start_dir_in=1) uses dior_n. The dd_in value present in the last low cycle of each strobe appears on rx_data with rx_valid high. It is held until rx_ready is seen, and words come out in bus order.
- R5: Data-out (start_dir_in=0) uses diow_n. Each strobe takes one tx word, in order. dd_oe is high and dd_out is steady from the cycle before the strobe falls until the cycle after it rises, and the word the device captures at the rising edge is that tx word.
- R6: If the request is seen low during a strobe, that strobe still completes its word, but no further strobe is issued and dmack_n is released. Detection needs act_cycles of at least SYNC_STAGES+1.
- R7: After a release with words still remaining, a new burst begins once the request is high again. With no local stalls, a device that ends every burst after L words gives ceil(N/L) bursts for N words.
- R8: At the end of each recovery period, the host ends the burst when it cannot continue. For data-in this means the previous word is still unaccepted and rx_ready is low. For data-out it means tx_valid is low. The host then releases dmack_n with no further strobe while the request stays high, and resumes once the local side is ready.
- R9: Exactly start_words strobes are issued per command. done pulses for one cycle, with dmack_n high, right after the last release. busy is high from the accepted start until that pulse.
- R10: A start with start_words=0 raises done in the next cycle and never asserts dmack_n.
- R11: A start pulse while busy is ignored, and the running transfer keeps its word count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a command (accepted only when idle) |
| start_dir_in | input | 1 | 1: device to host via dior_n; 0: host to device via diow_n |
| start_words | input | CNT_W | Words to move for this command |
| act_cycles | input | TIME_W | Strobe low width in cycles (0 acts as 1) |
| rec_cycles | input | TIME_W | Recovery width; gap between strobes is this plus one |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dmarq | input | 1 | Device DMA request, asynchronous |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_in | input | DATA_W | Bus data from the pad |
| dd_out | output | DATA_W | Bus data to the pad |
| dd_oe | output | 1 | Pad drive enable for dd_out |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Local sink accepts rx_data |
| rx_data | output | DATA_W | Received word |
| tx_valid | input | 1 | Local source offers tx_data |
| tx_ready | output | 1 | Sequencer takes tx_data this cycle |
| tx_data | input | DATA_W | Word to send |

## Verification
The bench builds the block with a 16-bit bus, an 8-bit word count, 4-bit timing fields and a two-stage request synchronizer. It sweeps both directions, strobe widths of 3 to 5 cycles and recovery settings of 1 to 3 cycles. It uses single-word and five-word commands, against a device that either ends a burst every two words or never. Every width of 3 or more leaves room for the two-stage synchronizer to see a request drop inside the strobe, so device endings and resumptions fall inside the swept space. Periodic stalls on the local stream cause host endings. Separate directed runs cover a long host stall, a zero-length command and a start that arrives mid-transfer.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WAIT = 3'd1,
      ST_PREP = 3'd2,
      ST_ACT  = 3'd3,
      ST_REC  = 3'd4,
      ST_HOLD = 3'd5
   } seq_state_t;

   function automatic logic ack_low(input seq_state_t s);
      return (s == ST_PREP) || (s == ST_ACT) || (s == ST_REC) || (s == ST_HOLD);
   endfunction

endpackage

// File: rtl/mwdma_req_sync.sv
module mwdma_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 4)
         else $error("mwdma_req_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_direct
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= async_in;
               for (int i = 1; i < STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign sync_out = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mwdma_phase_timer.sv
module mwdma_phase_timer #(
   parameter int TIME_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] load_len,
   output logic              expired
);

   initial begin
      assert (TIME_W >= 2 && TIME_W <= 16)
         else $error("mwdma_phase_timer: TIME_W must be 2..16");
   end

   logic [TIME_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (load_len == '0) ? '0 : load_len - TIME_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - TIME_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/mwdma_word_counter.sv
module mwdma_word_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);

   initial begin
      assert (CNT_W >= 1 && CNT_W <= 32)
         else $error("mwdma_word_counter: CNT_W must be 1..32");
   end

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= load_val;
      end else if (dec) begin
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign zero = (left_q == '0);

   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !zero);

endmodule

// File: rtl/mwdma_host_seq.sv
module mwdma_host_seq
   import mwdma_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 16,
   parameter int TIME_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_dir_in,
   input  logic [CNT_W-1:0]  start_words,
   input  logic [TIME_W-1:0] act_cycles,
   input  logic [TIME_W-1:0] rec_cycles,
   output logic              busy,
   output logic              done,
   input  logic              dmarq,
   output logic              dmack_n,
   output logic              dior_n,
   output logic              diow_n,
   input  logic [DATA_W-1:0] dd_in,
   output logic [DATA_W-1:0] dd_out,
   output logic              dd_oe,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [DATA_W-1:0] rx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DATA_W-1:0] tx_data
);

   initial begin
      assert (DATA_W >= 8 && DATA_W <= 32)
         else $error("mwdma_host_seq: DATA_W must be 8..32");
   end

   seq_state_t        st_q, st_d;
   logic              dir_in_q;
   logic              dev_end_q;
   logic              rec_first_q;
   logic              rx_vld_q;
   logic              done_q;
   logic [TIME_W-1:0] act_q, rec_q;
   logic [DATA_W-1:0] rx_q, dout_q;

   logic rq_s, t_exp, cnt_zero;
   logic host_ok, strobe_end, go_prep, accept_start, t_load;
   logic [TIME_W-1:0] t_len;

   mwdma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (dmarq),
      .sync_out (rq_s)
   );

   assign t_load = (st_q == ST_PREP) || strobe_end;
   assign t_len  = (st_q == ST_PREP) ? act_q : rec_q;

   mwdma_phase_timer #(.TIME_W(TIME_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_len (t_len),
      .expired  (t_exp)
   );

   mwdma_word_counter #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept_start),
      .load_val (start_words),
      .dec      (strobe_end),
      .zero     (cnt_zero)
   );

   assign accept_start = (st_q == ST_IDLE) && start;
   assign host_ok      = dir_in_q ? (!rx_vld_q || rx_ready) : tx_valid;
   assign strobe_end   = (st_q == ST_ACT) && t_exp;
   assign go_prep      = ((st_q == ST_WAIT) && rq_s && host_ok) ||
                         ((st_q == ST_REC) && t_exp && !cnt_zero && !dev_end_q && host_ok);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (accept_start && start_words != '0) st_d = ST_WAIT;
         ST_WAIT: if (go_prep) st_d = ST_PREP;
         ST_PREP: st_d = ST_ACT;
         ST_ACT:  if (t_exp) st_d = ST_REC;
         ST_REC:  if (t_exp) st_d = go_prep ? ST_PREP : ST_HOLD;
         ST_HOLD: st_d = cnt_zero ? ST_IDLE : ST_WAIT;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         dir_in_q    <= 1'b0;
         act_q       <= '0;
         rec_q       <= '0;
         dev_end_q   <= 1'b0;
         rec_first_q <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         st_q        <= st_d;
         rec_first_q <= strobe_end;
         done_q      <= (accept_start && start_words == '0) ||
                        ((st_q == ST_HOLD) && cnt_zero);
         if (accept_start) begin
            dir_in_q <= start_dir_in;
            act_q    <= act_cycles;
            rec_q    <= rec_cycles;
         end
         if (st_q == ST_PREP) begin
            dev_end_q <= 1'b0;
         end else if ((st_q == ST_ACT) && !rq_s) begin
            dev_end_q <= 1'b1;
         end
      end
   end

   // receive holding register: one word, filled on the strobe's rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_vld_q <= 1'b0;
         rx_q     <= '0;
      end else if (strobe_end && dir_in_q) begin
         rx_vld_q <= 1'b1;
         rx_q     <= dd_in;
      end else if (rx_ready) begin
         rx_vld_q <= 1'b0;
      end
   end

   // transmit word register: loaded one cycle ahead of the write strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
      end else if (tx_ready) begin
         dout_q <= tx_data;
      end
   end

   assign tx_ready = go_prep && !dir_in_q;
   assign busy     = (st_q != ST_IDLE);
   assign done     = done_q;
   assign dmack_n  = !ack_low(st_q);
   assign dior_n   = !((st_q == ST_ACT) && dir_in_q);
   assign diow_n   = !((st_q == ST_ACT) && !dir_in_q);
   assign dd_oe    = !dir_in_q && ((st_q == ST_PREP) || (st_q == ST_ACT) ||
                                   ((st_q == ST_REC) && rec_first_q));
   assign dd_out   = dout_q;
   assign rx_valid = rx_vld_q;
   assign rx_data  = rx_q;

   // R2
   strobe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dior_n || !diow_n) |-> !dmack_n);

   // R2
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dmack_n) |-> $past(dior_n && diow_n));

   // R5
   wr_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !diow_n |-> (dd_oe && $stable(dd_out)));

   // R4
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

   // R6
   dev_end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_REC) && t_exp && dev_end_q) |=> (st_q == ST_HOLD));

   // R9
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (dmack_n && !busy));

endmodule

// File: tb/sim_mwdma_host_seq.sv
module sim_mwdma_host_seq;

   localparam int DW = 16;
   localparam int CW = 8;
   localparam int TW = 4;
   localparam int SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic start_dir_in = 1'b0;
   logic [CW-1:0] start_words = '0;
   logic [TW-1:0] act_cycles = '0;
   logic [TW-1:0] rec_cycles = '0;
   logic busy, done;
   logic dmarq = 1'b0;
   logic dmack_n, dior_n, diow_n;
   logic [DW-1:0] dd_in = '0;
   logic [DW-1:0] dd_out;
   logic dd_oe;
   logic rx_valid;
   logic rx_ready = 1'b1;
   logic [DW-1:0] rx_data;
   logic tx_valid = 1'b0;
   logic tx_ready;
   logic [DW-1:0] tx_data = '0;

   mwdma_host_seq #(.DATA_W(DW), .CNT_W(CW), .TIME_W(TW), .SYNC_STAGES(SS)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_dir_in(start_dir_in),
      .start_words(start_words), .act_cycles(act_cycles), .rec_cycles(rec_cycles),
      .busy(busy), .done(done), .dmarq(dmarq), .dmack_n(dmack_n),
      .dior_n(dior_n), .diow_n(diow_n), .dd_in(dd_in), .dd_out(dd_out),
      .dd_oe(dd_oe), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int k, input int salt);
      return DW'(k * 16'h1357 + salt * 16'h00A1) ^ 16'hC3A5;
   endfunction

   // run configuration
   bit run_on = 0;
   bit kick = 0;
   bit cfg_din = 0;
   int cfg_act = 1, cfg_rec = 1, cfg_n = 0, cfg_l = 1, cfg_mode = 0, salt = 0;

   // observations
   int cyc = 0;
   int total = 0, burst_cnt = 0, bursts = 0, gap = 0;
   int lo_run = 0, hi_run = 0;
   int rd_done = 0, rx_got = 0, wr_cap = 0, tx_pops = 0;
   int stray = 0, setup_err = 0, hold_err = 0, gap_err = 0, width_err = 0;
   int post_drop = 0, oe_err = 0, data_err = 0, done_cnt = 0, done_err = 0, ack_err = 0;
   bit had_strobe = 0, dropped = 0, tx_pop_pend = 0;
   bit prev_low = 0, prev_ack_n = 1, prev_oe = 0;

   always begin
      @(negedge clk);
      cyc++;
      if (tx_pop_pend) begin
         tx_pops++;
         tx_pop_pend = 0;
      end
      if (kick) begin
         kick = 0;
         dmarq = 1'b1;
         dd_in = pat(0, salt);
      end
      begin
         bit low;
         low = !dior_n || !diow_n;
         if (low && dmack_n) stray++;
         if (done) begin
            done_cnt++;
            if (dmack_n !== 1'b1) done_err++;
         end
         if (!dmack_n && prev_ack_n) begin
            bursts++;
            if (!dmarq) ack_err++;
            had_strobe = 0;
            burst_cnt = 0;
         end
         if (dmack_n && !prev_ack_n) begin
            if (hi_run < 2 || low) hold_err++;
            had_strobe = 0;
            dropped = 0;
            burst_cnt = 0;
         end
         if (low && !prev_low) begin
            if (prev_ack_n) setup_err++;
            if (had_strobe && hi_run != cfg_rec + 1) gap_err++;
            if (dropped) post_drop++;
            if (!cfg_din && !prev_oe) oe_err++;
            total++;
            burst_cnt++;
            if (burst_cnt == cfg_l || total == cfg_n) begin
               dmarq = 1'b0;
               dropped = 1;
               gap = 4;
            end
            lo_run = 0;
         end
         if (low) lo_run++;
         if (!low && prev_low) begin
            if (lo_run != cfg_act) width_err++;
            if (cfg_din) begin
               rd_done++;
               dd_in = pat(rd_done, salt);
            end else begin
               if (!dd_oe) oe_err++;
               if (dd_out != pat(wr_cap, salt)) data_err++;
               wr_cap++;
            end
            hi_run = 0;
            had_strobe = 1;
         end
         if (!low) hi_run++;
         if (!dmarq && dmack_n && gap > 0) gap--;
         else if (!dmarq && dmack_n && gap == 0 && run_on && total < cfg_n && dropped == 0 && total > 0)
            dmarq = 1'b1;
         prev_low = low;
         prev_ack_n = dmack_n;
         prev_oe = dd_oe;
      end
      rx_ready = (cfg_mode == 1 && cfg_din) ? ((cyc % 11) >= 5) : 1'b1;
      if (cfg_din) tx_valid = 1'b0;
      else if (cfg_mode == 0) tx_valid = 1'b1;
      else if (cfg_mode == 1) tx_valid = ((cyc % 11) >= 5);
      else tx_valid = (tx_pops < 2);
      tx_data = pat(tx_pops, salt);
      #1;
      if (run_on && rx_valid && rx_ready) begin
         if (rx_data != pat(rx_got, salt)) data_err++;
         rx_got++;
      end
      if (tx_ready && tx_valid) tx_pop_pend = 1;
   end

   task automatic launch(input bit din, input int a, input int r, input int n,
                         input int l, input int mode);
      @(negedge clk);
      cfg_din = din; cfg_act = a; cfg_rec = r; cfg_n = n; cfg_l = l; cfg_mode = mode;
      salt++;
      total = 0; burst_cnt = 0; bursts = 0; gap = 0; rd_done = 0; rx_got = 0;
      wr_cap = 0; tx_pops = 0; stray = 0; setup_err = 0; hold_err = 0; gap_err = 0;
      width_err = 0; post_drop = 0; oe_err = 0; data_err = 0; done_cnt = 0;
      done_err = 0; ack_err = 0; had_strobe = 0; dropped = 0; tx_pop_pend = 0;
      run_on = 1;
      kick = 1;
      start = 1'b1;
      start_dir_in = din;
      start_words = CW'(n);
      act_cycles = TW'(a);
      rec_cycles = TW'(r);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_run(input bit check_bursts);
      int moved;
      for (int i = 0; i < 4000 && done_cnt == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      moved = cfg_din ? rx_got : wr_cap;
      chk(total == cfg_n, "R9 strobe count", total, cfg_n);
      chk(done_cnt == 1 && done_err == 0, "R9 done pulse", done_cnt, 1);
      chk(moved == cfg_n, cfg_din ? "R4 words delivered" : "R5 words sent", moved, cfg_n);
      chk(data_err == 0, cfg_din ? "R4 data order" : "R5 data order", data_err, 0);
      chk(width_err == 0, "R3 strobe low width", width_err, 0);
      chk(gap_err == 0, "R3 strobe spacing", gap_err, 0);
      chk(stray == 0 && ack_err == 0, "R2 strobe/ack gating", stray + ack_err, 0);
      chk(setup_err == 0 && hold_err == 0, "R2 ack setup/hold", setup_err + hold_err, 0);
      chk(post_drop == 0, "R6 no strobe after device end", post_drop, 0);
      if (!cfg_din) chk(oe_err == 0, "R5 output enable window", oe_err, 0);
      if (check_bursts)
         chk(bursts == (cfg_n + cfg_l - 1) / cfg_l, "R7 burst count", bursts, (cfg_n + cfg_l - 1) / cfg_l);
      else
         chk(bursts >= (cfg_n + cfg_l - 1) / cfg_l, "R8 burst count lower bound", bursts, (cfg_n + cfg_l - 1) / cfg_l);
      run_on = 0;
      dmarq = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(dmack_n && dior_n && diow_n && !dd_oe && !done && !busy && !rx_valid,
          "R1 reset state", {dmack_n, dior_n, diow_n, dd_oe, done, busy, rx_valid}, 7'b1110000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(dmack_n && dior_n && diow_n && !dd_oe && !done && !busy,
          "R1 idle after reset", {dmack_n, dior_n, diow_n, dd_oe, done, busy}, 6'b111000);

      // R10 zero-length command
      @(negedge clk);
      start = 1'b1; start_words = '0; start_dir_in = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1 && dmack_n == 1'b1, "R10 done next cycle", done, 1);
      @(negedge clk);
      chk(done == 1'b0 && dmack_n == 1'b1 && !busy, "R10 single pulse no ack", done, 0);

      // sweep
      for (int d = 0; d < 2; d++)
         for (int a = 3; a <= 5; a++)
            for (int r = 1; r <= 3; r++)
               for (int ni = 0; ni < 2; ni++)
                  for (int li = 0; li < 2; li++)
                     for (int m = 0; m < 2; m++) begin
                        launch(d[0], a, r, ni ? 5 : 1, li ? 100 : 2, m);
                        finish_run(m == 0);
                     end

      // R8 directed: source runs dry after two words while the device keeps requesting
      launch(1'b0, 4, 2, 6, 100, 2);
      for (int i = 0; i < 500 && tx_pops < 2; i++) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(total == 2, "R8 strobes before host end", total, 2);
      chk(dmack_n == 1'b1 && dmarq == 1'b1, "R8 ack released with request high", dmack_n, 1);
      cfg_mode = 0;
      finish_run(1'b0);
      chk(bursts == 2, "R8 resumed once", bursts, 2);

      // R11 directed: start pulse in the middle of a transfer
      launch(1'b1, 3, 1, 7, 100, 0);
      for (int i = 0; i < 500 && dmack_n; i++) @(negedge clk);
      start = 1'b1; start_words = CW'(3); start_dir_in = 1'b0;
      @(negedge clk);
      start = 1'b0;
      finish_run(1'b1);
      chk(total == 7, "R11 busy start ignored", total, 7);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule